// File: doc/BRIEF.md
# Inactivity Power-Down Timer

This block decides when a battery-powered board should remove its own supply. It runs from a free-running on-chip oscillator clock of roughly 4.4 MHz, which may be off by up to a quarter either way. It watches a bus of active-high user switch inputs and an active-low activity strobe from the application logic. Any sign of activity restarts a window of `TIMEOUT_CYCLES` clocks. If that whole window passes with no activity, the single output `pwr_off` goes high and stays high, and the count stops. A high level on that output is meant to turn off the external supply switch. The default window is 44,000,000 clocks, which is about ten seconds at the nominal oscillator rate. The only way to change the window is to change that parameter.

The control is a three-state machine. `ST_HOLD` means activity was seen at the last edge, and the counter is zero. `ST_COUNT` means the block is counting clean edges. `ST_OFF` means the terminal count was reached: the output is latched high and the counter is frozen.

The transitions are:
- Any state goes to `ST_HOLD` on activity (the *retrigger* transition).
- `ST_HOLD` or `ST_COUNT` goes to `ST_COUNT` on an inactive edge below the terminal count (the *advance* transition).
- `ST_HOLD` or `ST_COUNT` goes to `ST_OFF` on an inactive edge at the terminal count (the *expire* transition).
- `ST_OFF` stays in `ST_OFF` while there is no activity (the *latch* transition).

Switch inputs pass through a synchroniser of `SYNC_STAGES` flops before they can retrigger. The application strobe is taken as already synchronous. `TIMEOUT_CYCLES` must be at least 2.

Top module: `idle_shutdown_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `pwr_off` is 0 and the idle count is zero.
- R2: `pwr_off` stays 0 while activity is present and while fewer than `TIMEOUT_CYCLES` consecutive inactive clock edges have passed.
- R3: After reset or after the last retrigger, `pwr_off` rises to 1 right after the `TIMEOUT_CYCLES`-th consecutive inactive rising edge, and not one edge earlier.
- R4: Once `pwr_off` is 1, it stays 1 with the counter frozen for as long as no activity occurs.
- R5: A low level of `app_act_n` at a rising edge clears the count. A one-cycle strobe at the edge that would have been the last one before timeout restarts a full window of `TIMEOUT_CYCLES` inactive edges.
- R6: `sw_in` is active high. A switch level reaches the retrigger logic only after the two-flop synchroniser. A one-cycle press sampled at edge k retriggers at edge k+2, so the output reacts right after that edge.
- R7: Activity arriving while `pwr_off` is 1 drives `pwr_off` back to 0 and starts a fresh window.
- R8: Each bit of `sw_in` retriggers on its own, for every bit position 0 to `SW_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_in | input | SW_W | User switches, active high, asynchronous |
| app_act_n | input | 1 | Application activity strobe, active low, synchronous |
| pwr_off | output | 1 | Supply-kill level; 1 turns the supply off |

## Verification
The window is set small, and it is tried with three kinds of input.

- **Long quiet stretches.** These pin down the exact edge on which the output rises and show that the latched level holds.
- **One-cycle strobes and switch pulses at the last edge before timeout.** These separate a full restart from an off-by-one count. They also show the extra two edges of switch latency against the direct strobe, bit by bit.
- **Random mix.** Seeded random alternation between busy and quiet bursts is compared edge by edge with a bench model. This exposes wrong behaviour when activity lands inside the window, at its end, or after the latch.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_OFF   = 2'd2
    } idle_state_e;

endpackage

// File: rtl/switch_sync.sv
module switch_sync #(
    parameter int unsigned SW_W        = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW_W-1:0] sw_async,
    output logic [SW_W-1:0] sw_sync
);

    logic [SW_W-1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= sw_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end

                // Each stage follows its predecessor by exactly one edge (R6)
                assert_stage_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    stage_q[s] == $past(stage_q[s-1]));
            end
        end
    endgenerate

    assign sw_sync = stage_q[SYNC_STAGES-1];

    // Marks that the previous edge was taken out of reset
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // The first stage captures the raw switch level of the previous edge (R6)
    assert_first_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> stage_q[0] == $past(sw_async));

endmodule

// File: rtl/activity_detect.sv
module activity_detect #(
    parameter int unsigned SW_W = 4
) (
    input  logic [SW_W-1:0] sw_sync,
    input  logic            app_act_n,
    output logic            retrig
);

    always_comb begin
        retrig = !app_act_n;
        for (int b = 0; b < SW_W; b++) begin
            retrig = retrig | sw_sync[b];
        end
    end

endmodule

// File: rtl/idle_counter.sv
module idle_counter #(
    parameter int unsigned     CNT_W    = 26,
    parameter logic [CNT_W-1:0] LAST_CNT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign at_last = (cnt_q == LAST_CNT);

endmodule

// File: rtl/idle_shutdown_timer.sv
module idle_shutdown_timer
    import idle_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 44_000_000,
    parameter int unsigned SW_W           = 4,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW_W-1:0] sw_in,
    input  logic            app_act_n,
    output logic            pwr_off
);

    localparam int unsigned      CNT_W    = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [SW_W-1:0]  sw_sync;
    logic             retrig;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;
    idle_state_e      state_q;
    idle_state_e      state_d;

    switch_sync #(
        .SW_W        (SW_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_async (sw_in),
        .sw_sync  (sw_sync)
    );

    activity_detect #(
        .SW_W (SW_W)
    ) u_detect (
        .sw_sync   (sw_sync),
        .app_act_n (app_act_n),
        .retrig    (retrig)
    );

    idle_counter #(
        .CNT_W    (CNT_W),
        .LAST_CNT (LAST_CNT)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .cnt_q   (cnt_q),
        .at_last (at_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Next state: retrigger, advance, expire, latch
    always_comb begin
        state_d = state_q;
        if (retrig) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD, ST_COUNT: state_d = at_last ? ST_OFF : ST_COUNT;
                ST_OFF:            state_d = ST_OFF;
                default:           state_d = ST_HOLD;
            endcase
        end
    end

    // Outputs and counter control
    always_comb begin
        cnt_clr = retrig;
        cnt_inc = 1'b0;
        pwr_off = 1'b0;
        unique case (state_q)
            ST_HOLD, ST_COUNT: cnt_inc = !retrig && !at_last;
            ST_OFF:            pwr_off = 1'b1;
            default:           pwr_off = 1'b0;
        endcase
    end

    // R5 / R7: activity at an edge forces the supply back on
    assert_retrig_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retrig |=> !pwr_off);

    // R4: without activity the off state is kept
    assert_off_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_off && !retrig) |=> pwr_off);

    // R4: the counter does not move while latched off
    assert_off_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !retrig) |=> $stable(cnt_q));

    // R3: the output only rises from the terminal count
    assert_rise_at_terminal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off) |-> $past(at_last));

endmodule

// File: tb/idle_shutdown_timer_test.sv
`timescale 1ns/1ps
module idle_shutdown_timer_test;

    localparam int N  = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [SW-1:0] sw;
    logic          act_n;
    logic          pwr_off;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    idle_shutdown_timer #(
        .TIMEOUT_CYCLES (N),
        .SW_W           (SW),
        .SYNC_STAGES    (2)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_in     (sw),
        .app_act_n (act_n),
        .pwr_off   (pwr_off)
    );

    // Reference model of the requirements
    logic [SW-1:0] m_s1, m_s2;
    int            m_idle;
    bit            m_off;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_idle = 0; m_off = 1'b0;
        end else begin
            bit act;
            act  = (|m_s2) || !act_n;
            m_s2 = m_s1;
            m_s1 = sw;
            if (act) begin
                m_idle = 0; m_off = 1'b0;
            end else if (!m_off) begin
                m_idle++;
                if (m_idle == N) m_off = 1'b1;
            end
        end
    end

    function automatic bit exp_model();
        return m_off;
    endfunction

    function automatic bit exp_after_idle(int edges);
        return edges >= N;
    endfunction

    task automatic chk(string req, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pwr_off=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200_000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sw = '0; act_n = 1'b1;
        repeat (3) tick();
        chk("R1 in reset", pwr_off, 1'b0);
        rst_n = 1'b1;

        // R3 / R2: exact timeout from reset, R1 low right after release
        for (int k = 1; k <= N + 2; k++) begin
            tick();
            chk(k < N ? "R2 counting" : "R3 timeout", pwr_off, exp_after_idle(k));
        end

        // R4: latched level holds
        for (int k = 0; k < 20; k++) begin
            tick();
            chk("R4 hold", pwr_off, 1'b1);
        end

        // R7: strobe while off restores supply and starts a fresh window
        act_n = 1'b0; tick(); act_n = 1'b1;
        chk("R7 wake", pwr_off, 1'b0);
        for (int k = 1; k <= N; k++) begin
            tick();
            if (k >= N - 1) chk("R7 fresh window", pwr_off, exp_after_idle(k));
        end

        // R5: retrigger at the last edge before timeout
        act_n = 1'b0; tick(); act_n = 1'b1;
        for (int k = 1; k < N; k++) tick();
        chk("R5 before last", pwr_off, 1'b0);
        act_n = 1'b0; tick(); act_n = 1'b1;
        chk("R5 strobe at N", pwr_off, 1'b0);
        for (int k = 1; k <= N; k++) begin
            tick();
            if (k >= N - 1) chk("R5 restart", pwr_off, exp_after_idle(k));
        end

        // R6 / R8: one-cycle press per switch bit from the off state
        for (int b = 0; b < SW; b++) begin
            chk("R8 off before press", pwr_off, 1'b1);
            sw = SW'(1) << b; tick(); sw = '0;
            chk("R6 sync edge1", pwr_off, 1'b1);
            tick();
            chk("R6 sync edge2", pwr_off, 1'b1);
            tick();
            chk("R8 bit wake", pwr_off, 1'b0);
            for (int k = 1; k <= N; k++) begin
                tick();
                if (k >= N - 1) chk("R6 window after switch", pwr_off, exp_after_idle(k));
            end
        end

        // Random busy / quiet bursts against the model (R2, R4, R5, R7)
        for (int blk = 0; blk < 120; blk++) begin
            bit busy;
            busy = ($urandom_range(0, 1) == 1);
            for (int c = 0; c < 40; c++) begin
                tick();
                chk(exp_model() ? "R4 random" : "R2 random", pwr_off, exp_model());
                if (busy) begin
                    act_n = ($urandom_range(0, 11) != 0);
                    sw    = ($urandom_range(0, 15) == 0) ?
                            (SW'(1) << $urandom_range(0, SW - 1)) : '0;
                end else begin
                    act_n = 1'b1;
                    sw    = '0;
                end
            end
        end

        // R1: reset in the middle of the off state
        act_n = 1'b1; sw = '0;
        repeat (N + 4) tick();
        chk("R4 pre-reset", pwr_off, 1'b1);
        rst_n = 1'b0; tick();
        chk("R1 reset clears", pwr_off, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule